// File: doc/BRIEF.md
# Packet-Filter Integer Arithmetic Unit

This unit computes the arithmetic class of a 64-bit register machine used to run packet-filter programs. Each operation is issued with a start pulse. The issue carries a 4-bit operation code, a 16-bit modifier field, a width flag that selects 64-bit or 32-bit semantics, and the current destination and source operand values. The decoder upstream has already picked the source operand, either a register or an immediate. The unit returns the new destination value along with a one-cycle done strobe.

Most operations finish one cycle after issue. Division and remainder use a bit-serial restoring divider, so they hold the unit busy for several cycles. A zero divisor never traps: a quotient becomes zero and a remainder returns the dividend. The modifier field picks the signed forms of division and remainder and the width of sign-extending moves. Every other combination of code and modifier is flagged as illegal, and the destination passes through unchanged.

Top module: `pfx_alu`

## Requirements
- R1: Codes 0x0 (add), 0x1 (subtract, dst minus src) and 0x2 (multiply) return the low bits of the exact result and wrap silently at the operation width.
- R2: Codes 0x4 (OR), 0x5 (AND) and 0xa (XOR) return the bitwise combination of dst and src.
- R3: Code 0x6 shifts left, 0x7 shifts right logically and 0xc shifts right while filling with the sign bit. The shift amount is src masked to 6 bits in 64-bit mode and to 5 bits in 32-bit mode.
- R4: Code 0x8 returns the two's-complement negation of dst, whatever src holds.
- R5: Code 0xb with modifier 0 returns src. With modifier 8, 16 or 32 it returns the low 8, 16 or 32 bits of src, sign-extended.
- R6: Code 0x3 divides dst by src, unsigned with modifier 0 and signed (quotient truncated toward zero) with modifier 1. A zero divisor gives 0.
- R7: Code 0x9 returns the remainder of dst by src, unsigned with modifier 0 and signed with modifier 1. A zero divisor returns dst.
- R8: In signed division, the most negative value divided by -1 returns the dividend and its remainder is 0. A signed remainder takes the sign of the dividend.
- R9: When wide=0, only bits 31:0 of each operand are used, and bits 63:32 of every legal result are zero.
- R10: A code of 0xd to 0xf, or a modifier the code does not accept, raises illegal together with done, and result equals dst_in.
- R11: Codes other than 0x3 and 0x9 raise done exactly one cycle after the start edge. So do division and remainder when the divisor is zero. Division or remainder by a nonzero divisor keeps busy high until done, and a start seen while busy is ignored.
- R12: After reset, done, busy and illegal are low and result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Issue strobe, accepted while busy is low |
| op | input | 4 | Operation code |
| ofs | input | 16 | Modifier field (signedness / move width) |
| wide | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| dst_in | input | 64 | Destination operand value |
| src_in | input | 64 | Source operand value |
| result | output | 64 | New destination value, valid with done |
| done | output | 1 | One-cycle completion strobe |
| illegal | output | 1 | Unsupported code/modifier, valid with done |
| busy | output | 1 | Divider in progress |

## Verification
All sixteen codes are applied across six modifier values and both widths, using every ordered pair from a set of ten operands. The operand set holds zero, one, minus one, a small negative, both 64-bit extremes, the 32-bit sign boundary, and values whose high bits would change a shift if the shift mask were wrong. This sweep separates unsigned from signed division. It also catches an incorrect shift mask, a 32-bit result that is not zero-extended, and a zero-divisor rule applied to the wrong operation. Directed cases cover signed overflow in division, the sign of a remainder, issue latency, and a start pulse arriving while the divider is busy.

// File: rtl/pfx_alu_pkg.sv
package pfx_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'h0, OP_SUB  = 4'h1, OP_MUL = 4'h2, OP_DIV = 4'h3,
    OP_OR   = 4'h4, OP_AND  = 4'h5, OP_SHL = 4'h6, OP_SHR = 4'h7,
    OP_NEG  = 4'h8, OP_MOD  = 4'h9, OP_XOR = 4'ha, OP_MOV = 4'hb,
    OP_SAR  = 4'hc
  } alu_op_e;

  localparam logic [15:0] MOD_SIGNED = 16'd1;
  localparam logic [15:0] MOD_SX8    = 16'd8;
  localparam logic [15:0] MOD_SX16   = 16'd16;
  localparam logic [15:0] MOD_SX32   = 16'd32;
endpackage

// File: rtl/pfx_alu_exec.sv
module pfx_alu_exec
  import pfx_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [3:0]      op,
  input  logic [15:0]     ofs,
  input  logic            wide,
  input  logic [XLEN-1:0] dst,
  input  logic [XLEN-1:0] src,
  output logic [XLEN-1:0] res,
  output logic            ill,
  output logic            needs_div
);
  localparam int HLEN = XLEN / 2;
  localparam int SW   = $clog2(XLEN);

  logic [XLEN-1:0]        aw, bw, raw;
  logic signed [XLEN-1:0] as_s;
  logic [SW-1:0]          sh;
  logic                   legal, is_dm;

  always_comb begin
    aw   = wide ? dst : {{HLEN{1'b0}}, dst[HLEN-1:0]};
    bw   = wide ? src : {{HLEN{1'b0}}, src[HLEN-1:0]};
    as_s = wide ? dst : {{HLEN{dst[HLEN-1]}}, dst[HLEN-1:0]};
    sh   = wide ? src[SW-1:0] : {1'b0, src[SW-2:0]};
    is_dm = (op == OP_DIV) || (op == OP_MOD);
    legal = ((ofs == 16'd0) && (op <= OP_SAR))
         || (is_dm && (ofs == MOD_SIGNED))
         || ((op == OP_MOV) && ((ofs == MOD_SX8) || (ofs == MOD_SX16) || (ofs == MOD_SX32)));
    ill       = !legal;
    needs_div = legal && is_dm;
    raw = '0;
    case (alu_op_e'(op))
      OP_ADD: raw = aw + bw;
      OP_SUB: raw = aw - bw;
      OP_MUL: raw = aw * bw;
      OP_OR:  raw = aw | bw;
      OP_AND: raw = aw & bw;
      OP_XOR: raw = aw ^ bw;
      OP_SHL: raw = aw << sh;
      OP_SHR: raw = aw >> sh;
      OP_SAR: raw = as_s >>> sh;
      OP_NEG: raw = (~aw) + {{(XLEN-1){1'b0}}, 1'b1};
      OP_MOV: begin
        case (ofs)
          MOD_SX8:  raw = {{(XLEN-8){src[7]}}, src[7:0]};
          MOD_SX16: raw = {{(XLEN-16){src[15]}}, src[15:0]};
          MOD_SX32: raw = {{(XLEN-32){src[31]}}, src[31:0]};
          default:  raw = bw;
        endcase
      end
      default: raw = '0;
    endcase
    res = wide ? raw : {{HLEN{1'b0}}, raw[HLEN-1:0]};
  end
endmodule

// File: rtl/pfx_alu_div.sv
module pfx_alu_div #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [XLEN-1:0] num,
  input  logic [XLEN-1:0] den,
  output logic            done,
  output logic [XLEN-1:0] quo,
  output logic [XLEN-1:0] rem
);
  localparam int CW = $clog2(XLEN + 1);

  logic [XLEN-1:0] rem_q, rem_d, quo_q, quo_d, den_q, den_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            run_q, run_d, done_q, done_d, step_en;
  logic [XLEN:0]   trial, diff;
  logic            ge;

  always_comb begin
    trial   = {rem_q, quo_q[XLEN-1]};
    diff    = trial - {1'b0, den_q};
    ge      = trial >= {1'b0, den_q};
    rem_d   = rem_q;
    quo_d   = quo_q;
    den_d   = den_q;
    cnt_d   = cnt_q;
    run_d   = run_q;
    done_d  = 1'b0;
    step_en = go || run_q;
    if (go) begin
      rem_d = '0;
      quo_d = num;
      den_d = den;
      cnt_d = CW'(XLEN);
      run_d = 1'b1;
    end else if (run_q) begin
      rem_d = ge ? diff[XLEN-1:0] : trial[XLEN-1:0];
      quo_d = {quo_q[XLEN-2:0], ge};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0; quo_q <= '0; den_q <= '0; cnt_q <= '0;
      run_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (step_en) begin
        rem_q <= rem_d; quo_q <= quo_d; den_q <= den_d;
        cnt_q <= cnt_d; run_q <= run_d;
      end
    end
  end

  assign done = done_q;
  assign quo  = quo_q;
  assign rem  = rem_q;
endmodule

// File: rtl/pfx_alu.sv
module pfx_alu
  import pfx_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [3:0]      op,
  input  logic [15:0]     ofs,
  input  logic            wide,
  input  logic [XLEN-1:0] dst_in,
  input  logic [XLEN-1:0] src_in,
  output logic [XLEN-1:0] result,
  output logic            done,
  output logic            illegal,
  output logic            busy
);
  localparam int HLEN = XLEN / 2;
  localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

  logic [XLEN-1:0] c_res, aw, bw, as_v, bs_v, a_mag, b_mag;
  logic            c_ill, c_div, a_neg, b_neg, b_zero, accept, go;
  logic            dv_done;
  logic [XLEN-1:0] dv_quo, dv_rem, q_fix, r_fix, pick;

  logic [XLEN-1:0] res_q, res_d;
  logic            done_q, done_d, ill_q, ill_d, busy_q, busy_d;
  logic            qneg_q, qneg_d, rneg_q, rneg_d, wide_q, wide_d, mod_q, mod_d;
  logic            res_en, ctx_en;

  pfx_alu_exec #(.XLEN(XLEN)) u_exec (
    .op(op), .ofs(ofs), .wide(wide), .dst(dst_in), .src(src_in),
    .res(c_res), .ill(c_ill), .needs_div(c_div)
  );

  pfx_alu_div #(.XLEN(XLEN)) u_div (
    .clk(clk), .rst_n(rst_n), .go(go), .num(a_mag), .den(b_mag),
    .done(dv_done), .quo(dv_quo), .rem(dv_rem)
  );

  // operand conditioning for the divider
  always_comb begin
    aw     = wide ? dst_in : {{HLEN{1'b0}}, dst_in[HLEN-1:0]};
    bw     = wide ? src_in : {{HLEN{1'b0}}, src_in[HLEN-1:0]};
    as_v   = wide ? dst_in : {{HLEN{dst_in[HLEN-1]}}, dst_in[HLEN-1:0]};
    bs_v   = wide ? src_in : {{HLEN{src_in[HLEN-1]}}, src_in[HLEN-1:0]};
    a_neg  = (ofs == MOD_SIGNED) && as_v[XLEN-1];
    b_neg  = (ofs == MOD_SIGNED) && bs_v[XLEN-1];
    a_mag  = a_neg ? (~as_v) + ONE : aw;
    b_mag  = b_neg ? (~bs_v) + ONE : bw;
    b_zero = (bw == '0);
    q_fix  = qneg_q ? (~dv_quo) + ONE : dv_quo;
    r_fix  = rneg_q ? (~dv_rem) + ONE : dv_rem;
    pick   = mod_q ? r_fix : q_fix;
  end

  // next state
  always_comb begin
    accept = start && !busy_q;
    go     = 1'b0;
    res_d  = res_q;
    ill_d  = ill_q;
    busy_d = busy_q;
    done_d = 1'b0;
    qneg_d = qneg_q; rneg_d = rneg_q; wide_d = wide_q; mod_d = mod_q;
    res_en = 1'b0;
    ctx_en = 1'b0;
    if (busy_q) begin
      if (dv_done) begin
        res_d  = wide_q ? pick : {{HLEN{1'b0}}, pick[HLEN-1:0]};
        ill_d  = 1'b0;
        busy_d = 1'b0;
        done_d = 1'b1;
        res_en = 1'b1;
      end
    end else if (accept) begin
      res_en = 1'b1;
      ill_d  = c_ill;
      if (c_ill) begin
        res_d  = dst_in;
        done_d = 1'b1;
      end else if (c_div && b_zero) begin
        res_d  = (op == OP_MOD) ? aw : '0;
        done_d = 1'b1;
      end else if (c_div) begin
        go     = 1'b1;
        busy_d = 1'b1;
        ctx_en = 1'b1;
        qneg_d = a_neg ^ b_neg;
        rneg_d = a_neg;
        wide_d = wide;
        mod_d  = (op == OP_MOD);
        res_en = 1'b0;
      end else begin
        res_d  = c_res;
        done_d = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0; ill_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0;
      qneg_q <= 1'b0; rneg_q <= 1'b0; wide_q <= 1'b0; mod_q <= 1'b0;
    end else begin
      done_q <= done_d;
      busy_q <= busy_d;
      if (res_en) begin
        res_q <= res_d;
        ill_q <= ill_d;
      end
      if (ctx_en) begin
        qneg_q <= qneg_d; rneg_q <= rneg_d; wide_q <= wide_d; mod_q <= mod_d;
      end
    end
  end

  assign result  = res_q;
  assign done    = done_q;
  assign illegal = ill_q;
  assign busy    = busy_q;
endmodule

// File: rtl/pfx_alu_chk.sv
module pfx_alu_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [3:0]      op,
  input logic [15:0]     ofs,
  input logic            wide,
  input logic [XLEN-1:0] dst_in,
  input logic [XLEN-1:0] src_in,
  input logic [XLEN-1:0] result,
  input logic            done,
  input logic            illegal,
  input logic            busy
);
  localparam int HLEN = XLEN / 2;

  logic [XLEN-1:0] cap_dst, cap_src, neg_full;
  logic [3:0]      cap_op;
  logic            cap_wide, src_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_dst <= '0; cap_src <= '0; cap_op <= '0; cap_wide <= 1'b0;
    end else if (start && !busy) begin
      cap_dst <= dst_in; cap_src <= src_in; cap_op <= op; cap_wide <= wide;
    end
  end

  assign neg_full = (~cap_dst) + {{(XLEN-1){1'b0}}, 1'b1};
  assign src_zero = cap_wide ? (cap_src == '0) : (cap_src[HLEN-1:0] == '0);

  p_illegal_keeps_dst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> (result == cap_dst));

  p_upper_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal && !cap_wide) |-> (result[XLEN-1:HLEN] == '0));

  p_div_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal && cap_op == 4'h3 && src_zero) |-> (result == '0));

  p_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal && cap_op == 4'h8) |->
      (result == (cap_wide ? neg_full : {{HLEN{1'b0}}, neg_full[HLEN-1:0]})));

  p_single_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op != 4'h3 && op != 4'h9) |=> done);

  p_no_done_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
endmodule

bind pfx_alu pfx_alu_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .ofs(ofs), .wide(wide),
  .dst_in(dst_in), .src_in(src_in), .result(result), .done(done),
  .illegal(illegal), .busy(busy)
);

// File: tb/pfx_alu_tb.sv
module pfx_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op = '0;
  logic [15:0] ofs = '0;
  logic        wide = 1'b0;
  logic [63:0] dst_in = '0, src_in = '0;
  logic [63:0] result;
  logic        done, illegal, busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pfx_alu u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .ofs(ofs), .wide(wide),
    .dst_in(dst_in), .src_in(src_in), .result(result), .done(done),
    .illegal(illegal), .busy(busy)
  );

  localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;

  function automatic logic [63:0] val(int i);
    case (i)
      0: return 64'h0;
      1: return 64'h1;
      2: return 64'hffff_ffff_ffff_ffff;
      3: return 64'hffff_ffff_ffff_fff9;
      4: return MIN64;
      5: return 64'h7fff_ffff_ffff_ffff;
      6: return 64'h0000_0000_8000_0000;
      7: return 64'h0000_0001_0000_0025;
      8: return 64'h1234_5678_9abc_def0;
      default: return 64'h0000_0000_0000_0041;
    endcase
  endfunction

  function automatic logic [15:0] ofs_val(int i);
    case (i)
      0: return 16'd0;
      1: return 16'd1;
      2: return 16'd8;
      3: return 16'd16;
      4: return 16'd32;
      default: return 16'd3;
    endcase
  endfunction

  function automatic string tag(logic [3:0] o, logic ill);
    if (ill) return "R10";
    case (o)
      4'h0, 4'h1, 4'h2: return "R1";
      4'h4, 4'h5, 4'ha: return "R2";
      4'h6, 4'h7, 4'hc: return "R3";
      4'h8: return "R4";
      4'hb: return "R5";
      4'h3: return "R6";
      default: return "R7";
    endcase
  endfunction

  // reference model written from the requirements
  function automatic void model(input logic [3:0] o, input logic [15:0] f, input logic w,
                                input logic [63:0] d, input logic [63:0] s,
                                output logic [63:0] r, output logic ill);
    logic [63:0] a, b;
    logic signed [63:0] sa, sb;
    int sh;
    bit ok;
    a  = w ? d : {32'h0, d[31:0]};
    b  = w ? s : {32'h0, s[31:0]};
    sa = w ? d : {{32{d[31]}}, d[31:0]};
    sb = w ? s : {{32{s[31]}}, s[31:0]};
    sh = w ? int'(s[5:0]) : int'(s[4:0]);
    ok = (f == 0 && o <= 4'hc) || ((o == 4'h3 || o == 4'h9) && f == 1)
      || (o == 4'hb && (f == 8 || f == 16 || f == 32));
    ill = !ok;
    r = 64'h0;
    case (o)
      4'h0: r = a + b;
      4'h1: r = a - b;
      4'h2: r = a * b;
      4'h4: r = a | b;
      4'h5: r = a & b;
      4'ha: r = a ^ b;
      4'h6: r = a << sh;
      4'h7: r = a >> sh;
      4'hc: r = sa >>> sh;
      4'h8: r = 64'h0 - a;
      4'hb: r = (f == 8) ? {{56{s[7]}}, s[7:0]} : (f == 16) ? {{48{s[15]}}, s[15:0]} :
                (f == 32) ? {{32{s[31]}}, s[31:0]} : b;
      4'h3: begin
        if (b == 0) r = 0;
        else if (f == 0) r = a / b;
        else if (w && sa == MIN64 && sb == -64'sd1) r = sa;
        else r = sa / sb;
      end
      4'h9: begin
        if (b == 0) r = a;
        else if (f == 0) r = a % b;
        else if (w && sa == MIN64 && sb == -64'sd1) r = 0;
        else r = sa % sb;
      end
      default: r = 0;
    endcase
    if (!w) r = {32'h0, r[31:0]};
    if (ill) r = d;
  endfunction

  task automatic check64(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] o, input logic [15:0] f, input logic w,
                     input logic [63:0] d, input logic [63:0] s,
                     output logic [63:0] r, output logic ill, output int lat);
    @(negedge clk);
    op = o; ofs = f; wide = w; dst_in = d; src_in = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    r = result;
    ill = illegal;
    if (!done) begin
      checks++; errors++;
      $display("FAIL R11 no done actual=0 expected=1");
    end
  endtask

  task automatic exec_chk(logic [3:0] o, logic [15:0] f, logic w, logic [63:0] d, logic [63:0] s, string req);
    logic [63:0] r, er;
    logic ill, eill;
    int lat;
    bit slow;
    model(o, f, w, d, s, er, eill);
    run(o, f, w, d, s, r, ill, lat);
    check64(req, "result", r, er);
    check64(req, "illegal", {63'h0, ill}, {63'h0, eill});
    if (!w && !eill) check64("R9", "upper half", {32'h0, r[63:32]}, 64'h0);
    slow = !eill && (o == 4'h3 || o == 4'h9) && ((w ? s : {32'h0, s[31:0]}) != 0);
    checks++;
    if (slow ? (lat <= 1) : (lat != 1)) begin
      errors++;
      $display("FAIL R11 latency actual=%0d expected=%s", lat, slow ? ">1" : "1");
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 195000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<195000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    logic ill;
    int lat;
    repeat (3) @(negedge clk);
    // R12 reset state
    check64("R12", "done", {63'h0, done}, 64'h0);
    check64("R12", "busy", {63'h0, busy}, 64'h0);
    check64("R12", "illegal", {63'h0, illegal}, 64'h0);
    check64("R12", "result", result, 64'h0);
    rst_n = 1'b1;

    // R8 directed signed corner cases
    exec_chk(4'h3, 16'd1, 1'b1, MIN64, 64'hffff_ffff_ffff_ffff, "R8");
    exec_chk(4'h9, 16'd1, 1'b1, MIN64, 64'hffff_ffff_ffff_ffff, "R8");
    exec_chk(4'h3, 16'd1, 1'b0, 64'h8000_0000, 64'hffff_ffff, "R8");
    exec_chk(4'h9, 16'd1, 1'b0, 64'h8000_0000, 64'hffff_ffff, "R8");
    run(4'h9, 16'd1, 1'b1, 64'hffff_ffff_ffff_fff9, 64'd2, r, ill, lat);
    check64("R8", "-7 rem 2", r, 64'hffff_ffff_ffff_ffff);
    run(4'h9, 16'd1, 1'b1, 64'd7, 64'hffff_ffff_ffff_fffe, r, ill, lat);
    check64("R8", "7 rem -2", r, 64'd1);
    run(4'h3, 16'd1, 1'b1, 64'hffff_ffff_ffff_fff9, 64'd2, r, ill, lat);
    check64("R8", "-7 div 2", r, 64'hffff_ffff_ffff_fffd);

    // R11 start while busy is ignored
    @(negedge clk);
    op = 4'h3; ofs = 16'd0; wide = 1'b1; dst_in = 64'd100; src_in = 64'd7; start = 1'b1;
    @(negedge clk);
    op = 4'h0; dst_in = 64'd5; src_in = 64'd5;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 300) begin @(negedge clk); lat++; end
    check64("R11", "result with start during busy", result, 64'd14);
    begin
      int extra = 0;
      repeat (4) begin @(negedge clk); if (done) extra++; end
      check64("R11", "no extra done", 64'(extra), 64'h0);
    end

    // sweep
    for (int o = 0; o < 16; o++)
      for (int fi = 0; fi < 6; fi++)
        for (int w = 0; w < 2; w++)
          for (int i = 0; i < 10; i++)
            for (int j = 0; j < 10; j++) begin
              logic [63:0] er;
              logic eill;
              model(4'(o), ofs_val(fi), w[0], val(i), val(j), er, eill);
              exec_chk(4'(o), ofs_val(fi), w[0], val(i), val(j), tag(4'(o), eill));
            end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule